// File: doc/BRIEF.md
# Serial Programming Mode Entry Decoder

This block watches one input line that doubles as the chip reset and as a serial data line. The line is sampled on every rising edge of the master clock. Entry into programming mode takes a qualifying run of high samples, then one low start sample, then a 10-bit entry code sent one bit per clock, least significant bit first. On the clock edge that samples the last code bit, the code is combined with the levels of two control pins: the pulse pin and the supply-sense pin, where the supply-sense pin is a digital stand-in for high-voltage detection. Four programming targets exist, and this combination picks one of them.

Once a valid target has been picked, the block raises a programming-active flag and drives a one-hot target select. It keeps both for as long as the line stays low. Any high sample on the line ends programming mode, and a new entry needs a fresh qualifying run of high samples. A code or pin combination that names no target leaves the block in normal mode.

Top module: `prog_entry_decoder`

## Requirements
- R1: While rst_ni is low, prog_active_o is 0 and target_o is 4'b0000.
- R2: A low sample of line_i starts a code frame only when the block is waiting and at least PRE_CLKS (default 24) consecutive high samples came immediately before it. A low sample that follows a shorter run does not start a frame, and the code bits sent after it cause no entry.
- R3: After the start sample, the next 10 samples are code bits, one per clock. The first of them is bit 0 of the code. Entry can only take effect on the clock edge that samples the 10th bit.
- R4: Code MEM_CODE (default 10'h2B4) with {pulse_i, vsense_i} = 2'b11 selects the user array (target_o = 4'b0001). The same code with 2'b10 selects the key table (target_o = 4'b0010).
- R5: Code SEC_CODE (default 10'h0D9) with {pulse_i, vsense_i} = 2'b11 selects security bit 1 (target_o = 4'b0100). The same code with 2'b10 selects security bit 2 (target_o = 4'b1000).
- R6: Any other code, or either defined code with pulse_i = 0, leaves prog_active_o = 0 and target_o = 0, and the block goes back to waiting for a start sample.
- R7: prog_active_o and target_o take effect from the edge that samples the 10th bit. Both hold while line_i stays low, and changes on pulse_i or vsense_i during that time have no effect on target_o.
- R8: A high sample on line_i while active clears prog_active_o and target_o from that edge. A later start sample needs a new run of at least PRE_CLKS high samples.
- R9: target_o is always zero or one-hot, and it is nonzero exactly when prog_active_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Combined reset and serial data line |
| pulse_i | input | 1 | Pulse pin level |
| vsense_i | input | 1 | Supply-sense level (digital) |
| prog_active_o | output | 1 | Programming mode active |
| target_o | output | 4 | One-hot target: [0] user array, [1] key table, [2] security bit 1, [3] security bit 2 |

## Verification
The bench drives one preamble of exactly PRE_CLKS high samples and one that is one sample short. A counter that is off by one would enter on the short run or refuse the exact one. Every valid code and pin pair is sent. So are a corrupted code and a pin pair with pulse low, which catches swapped target bits, reversed bit order, or a decoder that lets an undefined combination through. The bench also toggles the pins while the block is active and aborts with a single high sample. It then tries to re-enter on that one high sample, so a design that latches the target late, ignores the abort, or keeps a stale preamble count is reported.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_ACTIVE = 2'd2
  } pe_state_e;

  localparam int unsigned N_TGT    = 4;
  localparam int unsigned TGT_USER = 0;
  localparam int unsigned TGT_KEY  = 1;
  localparam int unsigned TGT_SEC1 = 2;
  localparam int unsigned TGT_SEC2 = 3;
endpackage

// File: rtl/pe_preamble.sv
module pe_preamble #(
  parameter int unsigned PRE_CLKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(PRE_CLKS + 1);
  localparam logic [CW-1:0] PRE_MAX = CW'(PRE_CLKS);

  logic [CW-1:0] cnt_q;

  // counts consecutive high samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!line_i)          cnt_q <= '0;
    else if (cnt_q != PRE_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == PRE_MAX);

  p_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PRE_MAX);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !armed_o);
endmodule

// File: rtl/pe_shifter.sv
module pe_shifter #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [CODE_W-1:0] word_o,
  output logic              last_o
);
  localparam int unsigned IW = $clog2(CODE_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(CODE_W - 1);

  logic [CODE_W-1:0] sreg_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (en_i) begin
      sreg_q <= {bit_i, sreg_q[CODE_W-1:1]};
      idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  // word including the bit sampled this cycle, LSB first
  assign word_o = {bit_i, sreg_q[CODE_W-1:1]};
  assign last_o = en_i && (idx_q == LAST_IDX);

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
endmodule

// File: rtl/pe_decode.sv
module pe_decode
  import prog_entry_pkg::*;
#(
  parameter int unsigned       CODE_W   = 10,
  parameter logic [CODE_W-1:0] MEM_CODE = 10'h2B4,
  parameter logic [CODE_W-1:0] SEC_CODE = 10'h0D9
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              pulse_i,
  input  logic              vsense_i,
  output logic [N_TGT-1:0]  tgt_o
);
  always_comb begin
    tgt_o = '0;
    if (pulse_i) begin
      if (code_i == MEM_CODE) begin
        if (vsense_i) tgt_o[TGT_USER] = 1'b1;
        else          tgt_o[TGT_KEY]  = 1'b1;
      end else if (code_i == SEC_CODE) begin
        if (vsense_i) tgt_o[TGT_SEC1] = 1'b1;
        else          tgt_o[TGT_SEC2] = 1'b1;
      end
    end
  end

  always_comb begin
    a_dec_onehot_r9: assert ($onehot0(tgt_o));
  end
endmodule

// File: rtl/prog_entry_decoder.sv
module prog_entry_decoder
  import prog_entry_pkg::*;
#(
  parameter int unsigned       PRE_CLKS = 24,
  parameter int unsigned       CODE_W   = 10,
  parameter logic [CODE_W-1:0] MEM_CODE = 10'h2B4,
  parameter logic [CODE_W-1:0] SEC_CODE = 10'h0D9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             pulse_i,
  input  logic             vsense_i,
  output logic             prog_active_o,
  output logic [N_TGT-1:0] target_o
);
  pe_state_e         state_q, state_d;
  logic [N_TGT-1:0]  tgt_q, tgt_d, dec_tgt;
  logic [CODE_W-1:0] word;
  logic              armed, start, shift_last;

  pe_preamble #(.PRE_CLKS(PRE_CLKS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .armed_o(armed)
  );

  assign start = (state_q == ST_WAIT) && !line_i && armed;

  pe_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .en_i  (state_q == ST_SHIFT),
    .bit_i (line_i),
    .word_o(word),
    .last_o(shift_last)
  );

  pe_decode #(.CODE_W(CODE_W), .MEM_CODE(MEM_CODE), .SEC_CODE(SEC_CODE)) u_dec (
    .code_i  (word),
    .pulse_i (pulse_i),
    .vsense_i(vsense_i),
    .tgt_o   (dec_tgt)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      ST_WAIT:  if (start) state_d = ST_SHIFT;
      ST_SHIFT: if (shift_last) begin
        if (dec_tgt != '0) begin
          state_d = ST_ACTIVE;
          tgt_d   = dec_tgt;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_ACTIVE: if (line_i) begin
        state_d = ST_WAIT;
        tgt_d   = '0;
      end
      default: begin
        state_d = ST_WAIT;
        tgt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  assign prog_active_o = (state_q == ST_ACTIVE);
  assign target_o      = tgt_q;

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(target_o) && (prog_active_o == (target_o != '0)));
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_active_o && line_i |=> !prog_active_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_active_o && !line_i |=> prog_active_o && $stable(target_o));
  p_entry_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_active_o && !shift_last |=> !prog_active_o);
endmodule

// File: tb/prog_entry_decoder_tb.sv
module prog_entry_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 24;
  localparam logic [9:0] MEM_C = 10'h2B4;
  localparam logic [9:0] SEC_C = 10'h0D9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line = 1'b1, pulse = 1'b0, vsense = 1'b0;
  logic act;
  logic [3:0] tgt;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode = 0;  // 0 wait, 1 shifting, 2 active
  int m_run = 0, m_nbits = 0;
  int m_code = 0;
  logic [3:0] m_tgt = 4'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prog_entry_decoder u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .pulse_i      (pulse),
    .vsense_i     (vsense),
    .prog_active_o(act),
    .target_o     (tgt)
  );

  function automatic logic [3:0] ref_target(int code, logic p, logic v);
    if (!p) return 4'b0000;
    if (code == int'(MEM_C)) return v ? 4'b0001 : 4'b0010;
    if (code == int'(SEC_C)) return v ? 4'b0100 : 4'b1000;
    return 4'b0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_nbits = 0; m_code = 0; m_tgt = 4'b0;
    end else begin
      if (m_mode == 0) begin
        if (!line && m_run >= PRE) begin
          m_mode = 1; m_nbits = 0; m_code = 0;
        end
      end else if (m_mode == 1) begin
        if (line) m_code = m_code + (1 << m_nbits);
        m_nbits++;
        if (m_nbits == 10) begin
          m_tgt  = ref_target(m_code, pulse, vsense);
          m_mode = (m_tgt != 4'b0) ? 2 : 0;
        end
      end else if (line) begin
        m_mode = 0; m_tgt = 4'b0;
      end
      m_run = line ? m_run + 1 : 0;
    end
  end

  task automatic chk(string req, logic [4:0] actual, logic [4:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: act/tgt actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) chk(cur_req, {act, tgt}, {m_mode == 2, m_tgt});
  end

  task automatic step(logic b);
    @(negedge clk);
    line = b;
  endtask

  task automatic frame(int pre, logic [9:0] code, logic p, logic v);
    pulse = p; vsense = v;
    for (int i = 0; i < pre; i++) step(1'b1);
    step(1'b0);
    for (int b = 0; b < 10; b++) step(code[b]);
    @(negedge clk);
    line = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    chk("R1", {act, tgt}, 5'b0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R4";
    frame(30, MEM_C, 1'b1, 1'b1);
    chk("R4 user", {act, tgt}, 5'b10001);
    cur_req = "R7";
    idle(3);
    pulse = 1'b0; vsense = 1'b0;
    idle(4);
    chk("R7 pins ignored", {act, tgt}, 5'b10001);

    cur_req = "R8";
    step(1'b1);
    @(negedge clk);
    chk("R8 abort", {act, tgt}, 5'b00000);
    line = 1'b0;
    frame(0, MEM_C, 1'b1, 1'b1);
    chk("R8 no re-entry", {act, tgt}, 5'b00000);

    cur_req = "R2";
    frame(PRE - 1, MEM_C, 1'b1, 1'b1);
    chk("R2 short preamble", {act, tgt}, 5'b00000);
    frame(PRE, MEM_C, 1'b1, 1'b0);
    chk("R2 exact preamble / R4 key", {act, tgt}, 5'b10010);
    idle(2);

    cur_req = "R5";
    frame(PRE + 5, SEC_C, 1'b1, 1'b1);
    chk("R5 sec1", {act, tgt}, 5'b10100);
    idle(2);
    frame(PRE, SEC_C, 1'b1, 1'b0);
    chk("R5 sec2", {act, tgt}, 5'b11000);
    idle(2);

    cur_req = "R6";
    frame(PRE, MEM_C ^ 10'h001, 1'b1, 1'b1);
    chk("R6 bad code", {act, tgt}, 5'b00000);
    idle(3);
    frame(PRE, SEC_C, 1'b0, 1'b1);
    chk("R6 pulse low", {act, tgt}, 5'b00000);
    idle(3);

    cur_req = "R3";
    frame(PRE, {<<{MEM_C}}, 1'b1, 1'b1);
    chk("R3 bit order", {act, tgt}, 5'b00000);
    idle(2);
    frame(PRE, MEM_C, 1'b1, 1'b1);
    chk("R3 entry at 10th bit", {act, tgt}, 5'b10001);
    cur_req = "R9";
    idle(5);
    chk("R9 steady", {act, tgt}, 5'b10001);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule